// File: doc/BRIEF.md
# Service-Level Wormhole Mesh Router

This block is a five-port switch for a two-dimensional on-chip mesh. It has one port toward the attached module (local) and one toward each of the four neighbours (north, south, east, west). Every port has a flit-wide input channel and a flit-wide output channel. Packets travel by wormhole switching. A head flit carries the destination column and row. The body and tail flits follow the output that the head reserved. Routing is fixed and dimension-ordered: a packet first corrects its column, then its row, and then leaves on the local port. Comparators choose the output; no table is involved.

Every flit belongs to one of four service levels. Each input port keeps a small FIFO for each level. Each output port has its own wormhole reservation and its own downstream credit count for each level. Every cycle, an output grants the most urgent level that has a flit ready and a credit left, so a lower-level packet can be suspended between two of its flits and resumed later. Inputs that compete within one level are served round-robin. Flow control between neighbours uses credits, one per service level per link. This router pulses a credit back upstream for each flit it removes from an input queue. It spends one downstream credit for each flit it sends.

Each reservation is a two-state machine. In `RES_FREE` no packet owns the output at that level. The transition *claim* (a head flit is granted) moves it to `RES_HELD` and records the owning input. In `RES_HELD`, the transition *release* (the owner's tail flit is granted) returns it to `RES_FREE`. A single-flit packet is granted in `RES_FREE` and the state stays `RES_FREE`. Every other cycle keeps the current state.

Top module: `mesh_qos_router`

## Requirements
- R1: The output is chosen from the head flit's destination. If the column is greater than `MY_X`, the flit goes east (port 3). If the column is less, it goes west (port 4). If the column is equal and the row is greater than `MY_Y`, it goes north (port 1). If the row is less, it goes south (port 2). Otherwise it goes local (port 0). Port p occupies bits [p*FW +: FW] of the flat flit buses.
- R2: Flit layout, MSB first: kind (2 bits: 0 head, 1 body, 2 tail, 3 single), service level (2 bits), destination column (XW bits), destination row (YW bits), payload (DW bits). A flit leaves unchanged on the output, two clock edges after it was presented at an input with no competition.
- R3: Each input has a DEPTH-entry FIFO for each service level. The cycle after a flit is removed from input i, level s, `in_credit[i*4+s]` is high for one cycle.
- R4: Level 0 (signaling) has the highest priority, then 1 (real-time), then 2 (read/write), then 3 (block transfer). An output always sends the most urgent eligible level.
- R5: Inputs that compete for a new packet at the same output and level are served round-robin. The search starts after the last input granted there. After reset the search starts at input 0.
- R6: Once a head flit is granted, that output and level are held for its input until the tail flit is granted. Head flits from other inputs at that level wait.
- R7: A higher-level flit can take the output between two flits of a held lower-level packet. The lower-level packet then continues on the same output.
- R8: Each output keeps a credit counter for each level. It resets to DEPTH, drops by one for each flit sent, and rises by one for each pulse on `out_credit[o*4+s]`. No flit is sent at a level whose count is zero.
- R9: A flit that entered on the north or south input never leaves on the east or west output.
- R10: Synchronous active-high reset empties the queues, frees every reservation, and drives `out_valid` and `in_credit` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Flit present on input port p |
| in_flit | input | 5*FW | Input flits, port p at [p*FW +: FW] |
| in_credit | output | 20 | Credit pulse to upstream, bit p*4+level |
| out_valid | output | 5 | Flit present on output port p |
| out_flit | output | 5*FW | Output flits, port p at [p*FW +: FW] |
| out_credit | input | 20 | Credit pulse from downstream, bit p*4+level |

## Verification
A reservation stuck in `RES_HELD` freezes its output at that level. The next head flit from another input then fails to appear in the cycle it is due, two edges after entry. A release that comes too early shows up as a foreign flit landing between a packet's body and tail. A credit counter that is off by one shows up when credits are withheld: the cycle in which the output goes quiet shifts, either the third flit escapes or the second is held back. A wrong round-robin pointer or a wrong priority order reorders the flits on the very next contested cycle.

// File: rtl/mqr_pkg.sv
package mqr_pkg;

    localparam int NPORT = 5;
    localparam int NSL   = 4;

    localparam logic [2:0] DIR_LOCAL = 3'd0;
    localparam logic [2:0] DIR_NORTH = 3'd1;
    localparam logic [2:0] DIR_SOUTH = 3'd2;
    localparam logic [2:0] DIR_EAST  = 3'd3;
    localparam logic [2:0] DIR_WEST  = 3'd4;

    typedef enum logic [1:0] {
        FK_HEAD   = 2'd0,
        FK_BODY   = 2'd1,
        FK_TAIL   = 2'd2,
        FK_SINGLE = 2'd3
    } flit_kind_e;

    typedef enum logic {
        RES_FREE = 1'b0,
        RES_HELD = 1'b1
    } res_state_e;

    // Column first, then row, then local.
    function automatic logic [2:0] route_dir(int dx, int dy, int mx, int my);
        if (dx > mx)      return DIR_EAST;
        else if (dx < mx) return DIR_WEST;
        else if (dy > my) return DIR_NORTH;
        else if (dy < my) return DIR_SOUTH;
        return DIR_LOCAL;
    endfunction

endpackage

// File: rtl/mqr_sl_fifo.sv
module mqr_sl_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                mem[wr_q] <= din;
                wr_q      <= bump(wr_q);
            end
            if (pop) rd_q <= bump(rd_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign dout  = mem[rd_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));

    // R3: upstream honours credits, so a full queue is never written.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/mqr_in_port.sv
module mqr_in_port
    import mqr_pkg::*;
#(
    parameter int XW    = 2,
    parameter int YW    = 2,
    parameter int DW    = 8,
    parameter int DEPTH = 2,
    parameter int MY_X  = 1,
    parameter int MY_Y  = 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [4+XW+YW+DW-1:0]         in_flit,
    input  logic [NSL-1:0]                pop,
    output logic [NSL-1:0][4+XW+YW+DW-1:0] front,
    output logic [NSL-1:0]                avail,
    output logic [NSL-1:0]                is_head,
    output logic [NSL-1:0]                is_last,
    output logic [NSL-1:0][2:0]           dir
);
    localparam int FW = 4 + XW + YW + DW;

    logic [1:0] in_sl;
    assign in_sl = in_flit[FW-3 -: 2];

    for (genvar s = 0; s < NSL; s++) begin : g_sl
        logic       q_empty, q_full;
        logic [1:0] kind;

        mqr_sl_fifo #(.W(FW), .DEPTH(DEPTH)) u_q (
            .clk   (clk),
            .rst   (rst),
            .push  (in_valid && (in_sl == 2'(s))),
            .pop   (pop[s]),
            .din   (in_flit),
            .dout  (front[s]),
            .empty (q_empty),
            .full  (q_full)
        );

        assign kind       = front[s][FW-1 -: 2];
        assign avail[s]   = !q_empty;
        assign is_head[s] = (kind == FK_HEAD) || (kind == FK_SINGLE);
        assign is_last[s] = (kind == FK_TAIL) || (kind == FK_SINGLE);
        assign dir[s]     = route_dir(int'(front[s][FW-5 -: XW]),
                                      int'(front[s][FW-5-XW -: YW]),
                                      MY_X, MY_Y);

        // R3: a level's queue never holds more than DEPTH flits.
        p_full_hold_r3: assert property (@(posedge clk) disable iff (rst)
            (q_full && !pop[s]) |=> q_full);
    end

endmodule

// File: rtl/mqr_out_port.sv
module mqr_out_port
    import mqr_pkg::*;
#(
    parameter int NIN   = 5,
    parameter int DEPTH = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NSL-1:0][NIN-1:0]   q_avail,
    input  logic [NSL-1:0][NIN-1:0]   q_head,
    input  logic [NSL-1:0][NIN-1:0]   q_last,
    input  logic [NSL-1:0][NIN-1:0]   q_here,
    input  logic [NSL-1:0]            credit_ret,
    output logic [NSL-1:0][NIN-1:0]   grant,
    output logic                      fire
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(NIN);
    localparam int SW = $clog2(NSL);

    res_state_e          st_q   [NSL];
    res_state_e          st_d   [NSL];
    logic [IW-1:0]       owner_q[NSL];
    logic [IW-1:0]       last_q [NSL];
    logic [CW-1:0]       cred_q [NSL];

    logic [NSL-1:0][NIN-1:0] elig;
    logic [SW-1:0]           win_sl;
    logic [IW-1:0]           win_in;

    // Eligibility per level and input.
    always_comb begin
        for (int s = 0; s < NSL; s++) begin
            for (int i = 0; i < NIN; i++) begin
                elig[s][i] = q_avail[s][i] &&
                    ((st_q[s] == RES_FREE && q_head[s][i] && q_here[s][i]) ||
                     (st_q[s] == RES_HELD && owner_q[s] == IW'(i) && !q_head[s][i]));
            end
        end
    end

    // Output process: level priority, then round-robin among inputs.
    always_comb begin
        int idx;
        fire   = 1'b0;
        win_sl = '0;
        win_in = '0;
        grant  = '0;
        for (int s = NSL - 1; s >= 0; s--) begin
            if ((|elig[s]) && cred_q[s] != '0) begin
                fire   = 1'b1;
                win_sl = SW'(s);
            end
        end
        for (int k = NIN; k >= 1; k--) begin
            idx = (int'(last_q[win_sl]) + k) % NIN;
            if (elig[win_sl][idx]) win_in = IW'(idx);
        end
        if (fire) grant[win_sl][win_in] = 1'b1;
    end

    // Next-state logic of each reservation.
    always_comb begin
        for (int s = 0; s < NSL; s++) begin
            st_d[s] = st_q[s];
            unique case (st_q[s])
                RES_FREE: if (|grant[s] && !q_last[s][win_in]) st_d[s] = RES_HELD; // claim
                RES_HELD: if (|grant[s] &&  q_last[s][win_in]) st_d[s] = RES_FREE; // release
                default:  st_d[s] = RES_FREE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        for (int s = 0; s < NSL; s++) begin
            if (rst) st_q[s] <= RES_FREE;
            else     st_q[s] <= st_d[s];
        end
    end

    // Owner, round-robin pointer and credit counters.
    always_ff @(posedge clk) begin
        for (int s = 0; s < NSL; s++) begin
            if (rst) begin
                owner_q[s] <= '0;
                last_q[s]  <= IW'(NIN - 1);
                cred_q[s]  <= CW'(DEPTH);
            end else begin
                if (|grant[s] && st_q[s] == RES_FREE) begin
                    owner_q[s] <= win_in;
                    last_q[s]  <= win_in;
                end
                cred_q[s] <= cred_q[s] - CW'(|grant[s]) + CW'(credit_ret[s]);
            end
        end
    end

    // R6: at most one flit leaves an output per cycle.
    p_one_grant_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    for (genvar s = 0; s < NSL; s++) begin : g_chk
        // R8: the counter never exceeds the downstream depth.
        p_credit_cap_r8: assert property (@(posedge clk) disable iff (rst)
            cred_q[s] <= CW'(DEPTH));
        // R6: a held reservation keeps its owner until the tail goes.
        p_hold_r6: assert property (@(posedge clk) disable iff (rst)
            (st_q[s] == RES_HELD && !(|grant[s] && q_last[s][owner_q[s]]))
            |=> (st_q[s] == RES_HELD && $stable(owner_q[s])));
    end

endmodule

// File: rtl/mesh_qos_router.sv
module mesh_qos_router
    import mqr_pkg::*;
#(
    parameter int XW    = 2,
    parameter int YW    = 2,
    parameter int DW    = 8,
    parameter int DEPTH = 2,
    parameter int MY_X  = 1,
    parameter int MY_Y  = 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NPORT-1:0]                  in_valid,
    input  logic [NPORT*(4+XW+YW+DW)-1:0]     in_flit,
    output logic [NPORT*NSL-1:0]              in_credit,
    output logic [NPORT-1:0]                  out_valid,
    output logic [NPORT*(4+XW+YW+DW)-1:0]     out_flit,
    input  logic [NPORT*NSL-1:0]              out_credit
);
    localparam int FW = 4 + XW + YW + DW;

    logic [NPORT-1:0][FW-1:0]             in_arr;
    logic [NPORT-1:0][NSL-1:0]            cr_arr;
    logic [NPORT-1:0][NSL-1:0][FW-1:0]    front;
    logic [NPORT-1:0][NSL-1:0]            avail, head, last, pop;
    logic [NPORT-1:0][NSL-1:0][2:0]       dir;
    logic [NPORT-1:0][NSL-1:0][NPORT-1:0] here_o, avail_o, head_o, last_o, grant_o;
    logic [NPORT-1:0]                     fire;
    logic [NPORT-1:0][FW-1:0]             xbar;
    logic [NPORT-1:0][FW-1:0]             out_q;
    logic [NPORT-1:0]                     vld_q;
    logic [NPORT-1:0][NSL-1:0]            ret_q;

    assign in_arr = in_flit;
    assign cr_arr = out_credit;

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        mqr_in_port #(
            .XW(XW), .YW(YW), .DW(DW), .DEPTH(DEPTH), .MY_X(MY_X), .MY_Y(MY_Y)
        ) u_in (
            .clk      (clk),
            .rst      (rst),
            .in_valid (in_valid[i]),
            .in_flit  (in_arr[i]),
            .pop      (pop[i]),
            .front    (front[i]),
            .avail    (avail[i]),
            .is_head  (head[i]),
            .is_last  (last[i]),
            .dir      (dir[i])
        );
    end

    // Regroup queue status by output: [output][level][input].
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int s = 0; s < NSL; s++) begin
                for (int i = 0; i < NPORT; i++) begin
                    here_o[o][s][i]  = (dir[i][s] == 3'(o));
                    avail_o[o][s][i] = avail[i][s];
                    head_o[o][s][i]  = head[i][s];
                    last_o[o][s][i]  = last[i][s];
                end
            end
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        mqr_out_port #(.NIN(NPORT), .DEPTH(DEPTH)) u_out (
            .clk        (clk),
            .rst        (rst),
            .q_avail    (avail_o[o]),
            .q_head     (head_o[o]),
            .q_last     (last_o[o]),
            .q_here     (here_o[o]),
            .credit_ret (cr_arr[o]),
            .grant      (grant_o[o]),
            .fire       (fire[o])
        );
    end

    // Crossbar and pop collection.
    always_comb begin
        pop  = '0;
        xbar = '0;
        for (int o = 0; o < NPORT; o++) begin
            for (int s = 0; s < NSL; s++) begin
                for (int i = 0; i < NPORT; i++) begin
                    if (grant_o[o][s][i]) begin
                        xbar[o]   = xbar[o] | front[i][s];
                        pop[i][s] = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            out_q <= '0;
            ret_q <= '0;
        end else begin
            vld_q <= fire;
            out_q <= xbar;
            ret_q <= pop;
        end
    end

    assign out_valid = vld_q;
    assign out_flit  = out_q;
    assign in_credit = ret_q;

    // R9: no turn from the row dimension back to the column dimension.
    for (genvar s = 0; s < NSL; s++) begin : g_turn
        p_no_yx_turn_r9: assert property (@(posedge clk) disable iff (rst)
            !(grant_o[DIR_EAST][s][DIR_NORTH] || grant_o[DIR_EAST][s][DIR_SOUTH] ||
              grant_o[DIR_WEST][s][DIR_NORTH] || grant_o[DIR_WEST][s][DIR_SOUTH]));
    end

    // R10: the cycle after reset, the outputs are quiet.
    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> (vld_q == '0 && ret_q == '0));

endmodule

// File: tb/mesh_qos_router_test.sv
`timescale 1ns/1ps
module mesh_qos_router_test;
    localparam int XW = 2, YW = 2, DW = 8, DEPTH = 2, MX = 1, MY = 1;
    localparam int FW = 4 + XW + YW + DW;
    localparam int NP = 5, NS = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NP-1:0]     in_valid = '0;
    logic [NP*FW-1:0]  in_flit = '0;
    logic [NP*NS-1:0]  in_credit;
    logic [NP-1:0]     out_valid;
    logic [NP*FW-1:0]  out_flit;
    logic [NP*NS-1:0]  out_credit;
    logic [NP*NS-1:0]  auto_cr = '0;
    logic [NP*NS-1:0]  man_cr = '0;
    logic [NP-1:0]     auto_en = '1;
    int total = 0, bad = 0;
    bit finished = 0;

    mesh_qos_router #(.XW(XW), .YW(YW), .DW(DW), .DEPTH(DEPTH), .MY_X(MX), .MY_Y(MY)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit),
        .in_credit(in_credit), .out_valid(out_valid), .out_flit(out_flit),
        .out_credit(out_credit)
    );

    always #2.5 clk = ~clk;

    assign out_credit = auto_cr | man_cr;

    // Downstream model: return one credit for every flit seen.
    always @(negedge clk) begin
        for (int p = 0; p < NP; p++)
            for (int s = 0; s < NS; s++)
                auto_cr[p*NS+s] = auto_en[p] && out_valid[p] &&
                                  (out_flit[p*FW+FW-3 -: 2] == 2'(s));
    end

    function automatic logic [FW-1:0] mk(int kind, int sl, int dx, int dy, int pl);
        return {2'(kind), 2'(sl), XW'(dx), YW'(dy), DW'(pl)};
    endfunction

    function automatic int exp_dir(int dx, int dy);
        if (dx > MX) return 3;
        if (dx < MX) return 4;
        if (dy > MY) return 1;
        if (dy < MY) return 2;
        return 0;
    endfunction

    function automatic bit legal(int i, int dx, int dy);
        case (i)
            1: return dx == MX && dy <= MY;
            2: return dx == MX && dy >= MY;
            3: return dx <= MX;
            4: return dx >= MX;
            default: return 1;
        endcase
    endfunction

    function automatic logic [FW:0] obs(int p);
        return {out_valid[p], out_flit[p*FW +: FW]};
    endfunction

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic put(int p, logic [FW-1:0] f);
        in_valid[p]        = 1'b1;
        in_flit[p*FW +: FW] = f;
    endtask

    task automatic clr();
        in_valid = '0;
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [FW-1:0] fa, fb, fc, fd;
        int pl;
        pl = 1;
        repeat (3) cyc();
        // R10: outputs quiet while and right after reset
        chk("R10 reset out_valid", 64'(out_valid), 0);
        chk("R10 reset in_credit", 64'(in_credit), 0);
        rst = 1'b0;
        cyc();
        chk("R10 idle after reset", 64'({out_valid, in_credit}), 0);

        // R1 R2 R3: sweep of every input, level and legal destination
        for (int i = 0; i < NP; i++)
            for (int s = 0; s < NS; s++)
                for (int dx = 0; dx < 3; dx++)
                    for (int dy = 0; dy < 3; dy++) begin
                        if (!legal(i, dx, dy)) continue;
                        fa = mk(3, s, dx, dy, pl);
                        pl = (pl + 7) % 256;
                        put(i, fa);
                        cyc(); clr(); cyc();
                        chk("R1 output port", 64'(out_valid), 64'(1 << exp_dir(dx, dy)));
                        chk("R2 flit unchanged", 64'(out_flit[exp_dir(dx, dy)*FW +: FW]), 64'(fa));
                        chk("R3 credit return", 64'(in_credit), 64'(1 << (i*NS + s)));
                        cyc();
                    end

        // R4: level priority, both orders of input index
        fa = mk(3, 3, 2, 1, 8'hA3); fb = mk(3, 1, 2, 1, 8'hB1);
        put(0, fa); put(4, fb);
        cyc(); clr(); cyc();
        chk("R4 urgent first", 64'(obs(3)), 64'({1'b1, fb}));
        cyc();
        chk("R4 lower second", 64'(obs(3)), 64'({1'b1, fa}));
        cyc();
        fa = mk(3, 0, 2, 0, 8'hA0); fb = mk(3, 2, 2, 0, 8'hB2);
        put(0, fa); put(4, fb);
        cyc(); clr(); cyc();
        chk("R4 signaling first", 64'(obs(3)), 64'({1'b1, fa}));
        cyc();
        chk("R4 read-write second", 64'(obs(3)), 64'({1'b1, fb}));
        cyc();

        // R7: signaling flit cuts into a block-transfer packet
        fa = mk(0, 3, 2, 2, 8'h10); fb = mk(1, 3, 0, 0, 8'h11);
        fc = mk(2, 3, 0, 0, 8'h12); fd = mk(3, 0, 2, 2, 8'h55);
        put(0, fa); cyc();
        put(0, fb); put(4, fd); cyc();
        in_valid[4] = 1'b0; put(0, fc);
        chk("R7 head out", 64'(obs(3)), 64'({1'b1, fa}));
        cyc(); clr();
        chk("R7 preempting flit", 64'(obs(3)), 64'({1'b1, fd}));
        cyc();
        chk("R7 body resumes", 64'(obs(3)), 64'({1'b1, fb}));
        cyc();
        chk("R7 tail resumes", 64'(obs(3)), 64'({1'b1, fc}));
        cyc();

        // R6: reservation blocks a competing head of the same level
        fa = mk(0, 2, 1, 1, 8'h20); fb = mk(1, 2, 0, 0, 8'h21);
        fc = mk(2, 2, 0, 0, 8'h22); fd = mk(3, 2, 1, 1, 8'h2F);
        put(1, fa); put(2, fd); cyc();
        in_valid[2] = 1'b0; put(1, fb); cyc();
        put(1, fc);
        chk("R6 head claims", 64'(obs(0)), 64'({1'b1, fa}));
        cyc(); clr();
        chk("R6 body not cut", 64'(obs(0)), 64'({1'b1, fb}));
        cyc();
        chk("R6 tail not cut", 64'(obs(0)), 64'({1'b1, fc}));
        cyc();
        chk("R6 waiter after release", 64'(obs(0)), 64'({1'b1, fd}));
        cyc();

        // R5: round-robin between north and south inputs
        fa = mk(3, 1, 1, 1, 8'h31); fb = mk(3, 1, 1, 1, 8'h32);
        fc = mk(3, 1, 1, 1, 8'h33); fd = mk(3, 1, 1, 1, 8'h34);
        put(1, fa); put(2, fb); cyc();
        put(1, fc); put(2, fd); cyc(); clr();
        chk("R5 first north", 64'(obs(0)), 64'({1'b1, fa}));
        cyc();
        chk("R5 then south", 64'(obs(0)), 64'({1'b1, fb}));
        cyc();
        chk("R5 back to north", 64'(obs(0)), 64'({1'b1, fc}));
        cyc();
        chk("R5 south again", 64'(obs(0)), 64'({1'b1, fd}));
        cyc();

        // R8: credits withheld on east, level 3
        auto_en[3] = 1'b0;
        cyc();
        fa = mk(3, 3, 2, 0, 8'h41); fb = mk(3, 3, 2, 0, 8'h42); fc = mk(3, 3, 2, 0, 8'h43);
        put(0, fa); cyc();
        put(0, fb); cyc();
        put(0, fc);
        chk("R8 first credit", 64'(obs(3)), 64'({1'b1, fa}));
        cyc(); clr();
        chk("R8 second credit", 64'(obs(3)), 64'({1'b1, fb}));
        cyc();
        chk("R8 stall at zero", 64'(out_valid[3]), 0);
        cyc();
        chk("R8 still stalled", 64'(out_valid[3]), 0);
        man_cr[3*NS+3] = 1'b1;
        cyc();
        man_cr = '0;
        chk("R8 credit not yet usable", 64'(out_valid[3]), 0);
        cyc();
        chk("R8 resume after credit", 64'(obs(3)), 64'({1'b1, fc}));
        man_cr[3*NS+3] = 1'b1;
        cyc(); cyc();
        man_cr = '0;
        auto_en[3] = 1'b1;
        cyc();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule